// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An 8-bit general-purpose I/O port. For each pin it holds a direction bit and a drive bit, and it returns a synchronized copy of the pad level. Software writes and reads these through a small strobe bus with one address per register. Toward the pads the block drives an output value, an output enable and a pull-up enable, and it takes the raw pad input.

A pin whose direction bit is 1 drives its drive bit onto the pad. A pin whose direction bit is 0 is an input. On an input pin the drive bit turns on the pull-up instead. A chip-wide pull-up disable input overrides every pull-up. A sleep input blanks the input path so that floating pads do not toggle internal logic. Reset clears the direction and drive registers asynchronously, so the pins float even when no clock is running.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, pad_oe_o, pad_out_o and pad_pu_o are all zero, and this holds without any clock edge. Reads of address 0 and address 1 return zero after reset.
- R2: A write strobe with addr_i = 0 loads wdata_i into the direction register on the next rising clock edge. A read of address 0 returns the stored value.
- R3: A write strobe with addr_i = 1 loads wdata_i into the drive register on the next rising clock edge. A read of address 1 returns the stored value.
- R4: pad_oe_o equals the direction register and pad_out_o equals the drive register, bit for bit.
- R5: For each bit, pad_pu_o is (not direction) AND drive AND (not pu_dis_i), computed combinationally, so pu_dis_i acts with no clock delay.
- R6: A read of address 2 returns pad_in_i as it was sampled two rising edges earlier, whatever the direction bits are.
- R7: While sleep_i is high, the synchronizer takes in zeros: two edges after sleep_i rises, reads of address 2 return 0 whatever the pad level.
- R8: A write strobe to address 2 or address 3 changes neither the direction register nor the drive register.
- R9: rdata_o is zero when rd_en_i is low, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register select: 0 direction, 1 drive, 2 pin |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pad_in_i | input | 8 | Raw pad levels |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad driver enable |
| pad_pu_o | output | 8 | Pad pull-up enable |
| pu_dis_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep, blanks the input path |

## Verification
On every clock cycle, the assertions check the register update rules: the loaded value follows a write strobe, and the register holds its value when no strobe addresses it. They also check the two-edge latency of the synchronizer, the zeros it passes while asleep, and that pu_dis_i suppresses the pull-ups. Only the bench scenarios can show two things. The first is that the pins float the moment reset falls, before any clock edge. The second is the full truth table of output enable, output value and pull-up, taken across a sweep of direction and drive patterns in both pull-up disable states.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DRV  = 2'd1,
    REG_PIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      drv_o
);
  logic [W-1:0] dir_q, drv_q;
  logic         wr_dir, wr_drv;

  assign wr_dir = wr_en_i && (addr_i == REG_DIR);
  assign wr_drv = wr_en_i && (addr_i == REG_DRV);

  // async clear: pins float even with no clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata_i;
      if (wr_drv) drv_q <= wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign drv_o = drv_q;

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> dir_o == $past(wdata_i));
  p_drv_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DRV) |=> drv_o == $past(wdata_i));
  p_dir_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_DIR) |=> $stable(dir_o));
  p_drv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_DRV) |=> $stable(drv_o));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             gated;

  // blank the input while asleep
  assign gated = sleep_i ? '0 : pad_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= gated;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni, 2) && !$past(sleep_i, 2)) |-> sync_o == $past(pad_i, 2));
    p_sleep_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni, 2) && $past(sleep_i, 2)) |-> sync_o == '0);
  end
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] drv_i,
  input  logic         pu_dis_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] pu_o
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    always_comb begin
      oe_o[b]  = dir_i[b];
      out_o[b] = drv_i[b];
      pu_o[b]  = !dir_i[b] && drv_i[b] && !pu_dis_i;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      pad_pu_o,
  input  logic              pu_dis_i,
  input  logic              sleep_i
);
  logic [W-1:0] dir, drv, pin_sync;

  gpio_port_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .dir_o(dir), .drv_o(drv)
  );

  gpio_port_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .sleep_i, .pad_i(pad_in_i), .sync_o(pin_sync)
  );

  gpio_port_pad #(.W(W)) u_pad (
    .dir_i(dir), .drv_i(drv), .pu_dis_i,
    .out_o(pad_out_o), .oe_o(pad_oe_o), .pu_o(pad_pu_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        REG_DIR: rdata_o = dir;
        REG_DRV: rdata_o = drv;
        REG_PIN: rdata_o = pin_sync;
        default: rdata_o = '0;
      endcase
    end
  end

  p_pu_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pu_dis_i |-> pad_pu_o == '0);
  p_pu_vs_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);
  p_oe_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> pad_oe_o == $past(wdata_i));
  p_idle_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 0, rst_ni = 0;
  logic       wr_en = 0, rd_en = 0, pu_dis = 0, sleep = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0;
  logic [7:0] rdata, pad_out, pad_oe, pad_pu;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
    .pu_dis_i(pu_dis), .sleep_i(sleep)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_en = 1; addr = a; #1; d = rdata; rd_en = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #1;
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 pu in reset", pad_pu, 8'h00);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    rd(2'd0, v); chk("R1 dir after reset", v, 8'h00);
    rd(2'd1, v); chk("R1 drv after reset", v, 8'h00);

    // R2 R3 R4 R5 sweep
    for (int d = 0; d < 256; d += 17) begin
      for (int o = 0; o < 256; o += 13) begin
        wr(2'd0, 8'(d)); wr(2'd1, 8'(o));
        rd(2'd0, v); chk("R2 dir readback", v, 8'(d));
        rd(2'd1, v); chk("R3 drv readback", v, 8'(o));
        chk("R4 oe", pad_oe, 8'(d));
        chk("R4 out", pad_out, 8'(o));
        pu_dis = 0; #1;
        chk("R5 pu", pad_pu, ~8'(d) & 8'(o));
        pu_dis = 1; #1;
        chk("R5 pu disabled", pad_pu, 8'h00);
        pu_dis = 0;
      end
    end

    // R8 ignored writes
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3);
    wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
    rd(2'd0, v); chk("R8 dir kept", v, 8'h5A);
    rd(2'd1, v); chk("R8 drv kept", v, 8'hC3);
    chk("R8 oe kept", pad_oe, 8'h5A);

    // R9 read gating
    #1; chk("R9 idle rdata", rdata, 8'h00);
    rd(2'd3, v); chk("R9 addr 3", v, 8'h00);

    // R6 synchronizer
    for (int p = 0; p < 256; p += 7) begin
      @(negedge clk); pad_in = 8'(p);
      if (p % 2 == 0) wr_en = 0;
      @(negedge clk);
      rd(2'd2, v);
      if (p > 0) chk("R6 one edge old", v, 8'(p - 7));
      @(negedge clk);
      rd(2'd2, v); chk("R6 pin read", v, 8'(p));
    end
    wr(2'd0, 8'hFF);
    @(negedge clk); pad_in = 8'h96;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R6 pin read as output", v, 8'h96);

    // R7 sleep
    @(negedge clk); pad_in = 8'hFF; sleep = 1;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R7 sleep zero", v, 8'h00);
    @(negedge clk); sleep = 0;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R7 wake", v, 8'hFF);

    // R1 async reset without clock edge
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
    #2; rst_ni = 0; #1;
    chk("R1 async oe", pad_oe, 8'h00);
    chk("R1 async out", pad_out, 8'h00);
    chk("R1 async pu", pad_pu, 8'h00);
    @(negedge clk); rst_ni = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule